// File: doc/BRIEF.md
# Multicart Outer Bank Address Combiner

This block sits beside an inner bank-switching core on a cartridge-style memory map and widens that core's reach across a large multicart ROM. The CPU programs three outer configuration registers, repeated through the $5000 page, and a mirroring register at $4025. The block merges the stored outer bases with the inner core's bank addresses to produce the final PRG and CHR ROM addresses. The inner core decides only the low address bits, and the run-time span setting sets how many.

The block also supplies the inner core's personality select and, for the personality that has two address lines, the register address lines it should see. Two modes bypass the inner core. A fixed-window PRG mode takes the PRG offset straight from the CPU address. A CHR-RAM mode sends picture accesses to RAM and makes the CHR-ROM device the upper half of a doubled PRG space.

Top module: `xb_outer_combiner`

## Requirements
- R1: After reset every configuration register is zero: `inner_kind` is 0, `chr_ram_en` is 0, the PRG span is 256 KiB, the CHR span is 256 KiB, both bases are 0, and `mirror_h` follows `inner_mirror_h`.
- R2: A write reaches a $5xxx register only when `cpu_addr & 16'hF003` equals 16'h5000, 16'h5001 or 16'h5002. Any other written address, including 16'h5003, changes no output.
- R3: A write to the 16'h5000 slot loads `inner_kind` from data bits 1:0 (0 and 1 are the scanline-counter type, 2 the serial type, 3 the dual-line type) and the CHR base from data bits 7:2, counted in 8 KiB units.
- R4: The mode register bits 6:4 set the CHR span: 1xx gives 8 KiB, 01x 128 KiB, 001 32 KiB and 000 256 KiB. `chr_addr` bits below the span come from `inner_chr`. Bits at or above the span come from CHR base × 8 KiB.
- R5: A write to the 16'h5001 slot loads the PRG base from data bits 7:2, counted in 16 KiB units. Data bits 1:0 are ignored.
- R6: With mode bit 4 clear, mode bits 3:2 set the PRG span: 00 gives 256 KiB, 01 128 KiB and 1x 8 KiB. `prg_addr` bits below the span come from `inner_prg`. Bits at or above the span come from the outer base.
- R7: With mode bit 4 set (fixed window), the PRG span is 32 KiB for 00, 16 KiB for 01 and 8 KiB for 1x. The bits below the span come from `cpu_addr`, so smaller windows repeat across $8000–$FFFF.
- R8: Mode bit 0 drives `chr_ram_en`. While it is set, the PRG base counts in 32 KiB units and the merged address gains one bit. `prg_in_chr` carries that top bit, and a 1 there means the access goes to the CHR-ROM device. While bit 0 is clear, `prg_in_chr` is 0.
- R9: A write to exactly 16'h4025 loads the mirroring bit from data bit 3 (0 vertical, 1 horizontal). `mirror_h` shows that bit while the fixed window is on and shows `inner_mirror_h` otherwise.
- R10: `core_addr` is `cpu_addr[1:0]` unless `inner_kind` is 3. For kind 3 it is {A3,A2} when A11 is 0 and {A2,A3} when A11 is 1, written as {bit1,bit0}.
- R11: A register write takes effect at the rising edge where `cpu_we` is high. Outputs derived from it change after that edge and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | CPU write strobe |
| inner_prg | input | PRG_AW (20) | Inner core PRG byte address |
| inner_chr | input | CHR_AW (19) | Inner core CHR byte address |
| inner_mirror_h | input | 1 | Inner core mirroring, 1 = horizontal |
| prg_addr | output | PRG_AW (20) | Final PRG address within the selected device |
| prg_in_chr | output | 1 | PRG access targets the CHR-ROM device |
| chr_addr | output | CHR_AW (19) | Final CHR ROM address |
| chr_ram_en | output | 1 | CHR accesses go to RAM |
| mirror_h | output | 1 | Selected mirroring, 1 = horizontal |
| inner_kind | output | 2 | Inner core personality select |
| core_addr | output | 2 | Register address lines for the inner core |

## Verification
Register contents change only at the rising edge that samples `cpu_we`. Every address output is a combinational function of those registers and the current inputs. A write is therefore seen one edge after it is presented, while inner-core addresses and CPU address lines act within the same cycle. The bench changes inputs 2 ns after a rising edge and compares every output with its behavioural model at the following falling edge. That places each pass-through result in the cycle it was driven and each register effect in the cycle after its edge. One explicit check also confirms that a write has not yet acted before its edge.

// File: rtl/xbank_pkg.sv
package xbank_pkg;

   localparam logic [15:0] DEC_MASK   = 16'hF003;
   localparam logic [15:0] SLOT_CHR   = 16'h5000;
   localparam logic [15:0] SLOT_PRG   = 16'h5001;
   localparam logic [15:0] SLOT_MODE  = 16'h5002;
   localparam logic [15:0] SLOT_MIRR  = 16'h4025;
   localparam int          BASE_FIELD = 6;

   typedef enum logic [1:0] {
      KIND_SCAN_A = 2'd0,
      KIND_SCAN_B = 2'd1,
      KIND_SERIAL = 2'd2,
      KIND_DUAL   = 2'd3
   } kind_e;

   typedef struct packed {
      logic [BASE_FIELD-1:0] chr_base;
      kind_e                 kind;
      logic [BASE_FIELD-1:0] prg_base;
      logic [2:0]            chr_size;
      logic [1:0]            prg_size;
      logic                  fixed_win;
      logic                  chr_ram;
      logic                  mir_h;
   } cfg_t;

   // span in address bits for the PRG side
   function automatic logic [4:0] prg_span_bits(input logic [1:0] sz, input logic fixed_win);
      if (sz[1])          return 5'd13;
      else if (fixed_win) return sz[0] ? 5'd14 : 5'd15;
      else                return sz[0] ? 5'd17 : 5'd18;
   endfunction

   // span in address bits for the CHR side
   function automatic logic [4:0] chr_span_bits(input logic [2:0] sz);
      if (sz[2])      return 5'd13;
      else if (sz[1]) return 5'd17;
      else if (sz[0]) return 5'd15;
      else            return 5'd18;
   endfunction

endpackage

// File: rtl/xb_cfg_regs.sv
module xb_cfg_regs
   import xbank_pkg::*;
(
   input  logic        clk,
   input  logic        rst,
   input  logic        cpu_we,
   input  logic [15:0] cpu_addr,
   input  logic [7:0]  cpu_wdata,
   output cfg_t        cfg
);

   logic [15:0] masked;
   logic        hit_chr, hit_prg, hit_mode, hit_mirr;

   assign masked   = cpu_addr & DEC_MASK;
   assign hit_chr  = cpu_we && (masked == SLOT_CHR);
   assign hit_prg  = cpu_we && (masked == SLOT_PRG);
   assign hit_mode = cpu_we && (masked == SLOT_MODE);
   assign hit_mirr = cpu_we && (cpu_addr == SLOT_MIRR);

   logic [7:0]            r_chr;
   logic [BASE_FIELD-1:0] r_prg;
   logic [6:2]            r_mode_hi;
   logic                  r_ram;
   logic                  r_mir;

   always_ff @(posedge clk) begin
      if (rst) begin
         r_chr     <= '0;
         r_prg     <= '0;
         r_mode_hi <= '0;
         r_ram     <= 1'b0;
         r_mir     <= 1'b0;
      end else begin
         if (hit_chr)  r_chr <= cpu_wdata;
         if (hit_prg)  r_prg <= cpu_wdata[7:2];
         if (hit_mode) begin
            r_mode_hi <= cpu_wdata[6:2];
            r_ram     <= cpu_wdata[0];
         end
         if (hit_mirr) r_mir <= cpu_wdata[3];
      end
   end

   always_comb begin
      cfg.chr_base  = r_chr[7:2];
      cfg.kind      = kind_e'(r_chr[1:0]);
      cfg.prg_base  = r_prg;
      cfg.chr_size  = r_mode_hi[6:4];
      cfg.prg_size  = r_mode_hi[3:2];
      cfg.fixed_win = r_mode_hi[4];
      cfg.chr_ram   = r_ram;
      cfg.mir_h     = r_mir;
   end

endmodule

// File: rtl/xb_span_merge.sv
module xb_span_merge #(
   parameter int W = 20
) (
   input  logic [W-1:0] outer,
   input  logic [W-1:0] inner,
   input  logic [4:0]   span_bits,
   output logic [W-1:0] merged
);

   if (W < 1 || W > 63) begin : g_bad_width
      $error("xb_span_merge: W out of range");
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      localparam logic [5:0] IDX = 6'(i);
      assign merged[i] = (IDX < {1'b0, span_bits}) ? inner[i] : outer[i];
   end

endmodule

// File: rtl/xb_reg_lines.sv
module xb_reg_lines
   import xbank_pkg::*;
(
   input  kind_e       kind,
   input  logic [11:0] cpu_addr,
   output logic [1:0]  core_addr
);

   logic unused_mid;
   assign unused_mid = ^{cpu_addr[10:4]};

   always_comb begin
      if (kind == KIND_DUAL) begin
         if (cpu_addr[11]) core_addr = {cpu_addr[2], cpu_addr[3]};
         else              core_addr = {cpu_addr[3], cpu_addr[2]};
      end else begin
         core_addr = cpu_addr[1:0];
      end
   end

endmodule

// File: rtl/xb_outer_combiner.sv
module xb_outer_combiner
   import xbank_pkg::*;
#(
   parameter int PRG_UNIT_W = 14,
   parameter int CHR_UNIT_W = 13,
   parameter int BASE_W     = 6,
   parameter int PRG_AW     = PRG_UNIT_W + BASE_W,
   parameter int CHR_AW     = CHR_UNIT_W + BASE_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [15:0]       cpu_addr,
   input  logic [7:0]        cpu_wdata,
   input  logic              cpu_we,
   input  logic [PRG_AW-1:0] inner_prg,
   input  logic [CHR_AW-1:0] inner_chr,
   input  logic              inner_mirror_h,
   output logic [PRG_AW-1:0] prg_addr,
   output logic              prg_in_chr,
   output logic [CHR_AW-1:0] chr_addr,
   output logic              chr_ram_en,
   output logic              mirror_h,
   output logic [1:0]        inner_kind,
   output logic [1:0]        core_addr
);

   localparam int PW      = PRG_AW + 1;
   localparam int WIN_W   = 15;
   localparam int WIN_PAD = PW - WIN_W;

   if (BASE_W != BASE_FIELD) begin : g_bad_base
      $error("xb_outer_combiner: base field is fixed by the register layout");
   end
   if (PRG_AW != PRG_UNIT_W + BASE_W || CHR_AW != CHR_UNIT_W + BASE_W) begin : g_bad_aw
      $error("xb_outer_combiner: address widths must equal unit plus base");
   end
   if (PRG_AW < 18 || CHR_AW < 18) begin : g_bad_span
      $error("xb_outer_combiner: widths must cover a 256 KiB span");
   end

   cfg_t cfg;
   logic fixed_win;

   xb_cfg_regs u_regs (
      .clk       (clk),
      .rst       (rst),
      .cpu_we    (cpu_we),
      .cpu_addr  (cpu_addr),
      .cpu_wdata (cpu_wdata),
      .cfg       (cfg)
   );

   assign fixed_win = cfg.fixed_win;

   // PRG side: outer base scaled by 16 KiB, or 32 KiB in the doubled space
   logic [PW-1:0] prg_outer, prg_inner, prg_full;
   logic [4:0]    prg_span;

   always_comb begin
      if (cfg.chr_ram) prg_outer = {cfg.prg_base, {(PRG_UNIT_W+1){1'b0}}};
      else             prg_outer = {1'b0, cfg.prg_base, {PRG_UNIT_W{1'b0}}};
      if (fixed_win)   prg_inner = {{WIN_PAD{1'b0}}, cpu_addr[WIN_W-1:0]};
      else             prg_inner = {1'b0, inner_prg};
      prg_span = prg_span_bits(cfg.prg_size, fixed_win);
   end

   xb_span_merge #(.W(PW)) u_prg_merge (
      .outer     (prg_outer),
      .inner     (prg_inner),
      .span_bits (prg_span),
      .merged    (prg_full)
   );

   assign prg_addr   = prg_full[PRG_AW-1:0];
   assign prg_in_chr = prg_full[PRG_AW];

   // CHR side: outer base scaled by 8 KiB
   logic [CHR_AW-1:0] chr_outer;
   logic [4:0]        chr_span;

   assign chr_outer = {cfg.chr_base, {CHR_UNIT_W{1'b0}}};
   assign chr_span  = chr_span_bits(cfg.chr_size);

   xb_span_merge #(.W(CHR_AW)) u_chr_merge (
      .outer     (chr_outer),
      .inner     (inner_chr),
      .span_bits (chr_span),
      .merged    (chr_addr)
   );

   assign chr_ram_en = cfg.chr_ram;
   assign mirror_h   = fixed_win ? cfg.mir_h : inner_mirror_h;
   assign inner_kind = cfg.kind;

   xb_reg_lines u_lines (
      .kind      (cfg.kind),
      .cpu_addr  (cpu_addr[11:0]),
      .core_addr (core_addr)
   );

endmodule

// File: rtl/xb_outer_combiner_chk.sv
module xb_outer_combiner_chk (
   input logic        clk,
   input logic        rst,
   input logic [15:0] cpu_addr,
   input logic [1:0]  cpu_wdata_lo,
   input logic        cpu_we,
   input logic [12:0] inner_prg_lo,
   input logic [12:0] inner_chr_lo,
   input logic        inner_mirror_h,
   input logic [12:0] prg_addr_lo,
   input logic [12:0] chr_addr_lo,
   input logic        chr_ram_en,
   input logic        mirror_h,
   input logic [1:0]  inner_kind,
   input logic [1:0]  core_addr,
   input logic        fixed_win
);

   logic [15:0] m;
   assign m = cpu_addr & 16'hF003;

   p_kind_load_r3: assert property (@(posedge clk) disable iff (rst)
      (cpu_we && m == 16'h5000) |=> inner_kind == $past(cpu_wdata_lo));

   p_ram_load_r8: assert property (@(posedge clk) disable iff (rst)
      (cpu_we && m == 16'h5002) |=> chr_ram_en == $past(cpu_wdata_lo[0]));

   p_stray_write_r2: assert property (@(posedge clk) disable iff (rst)
      (cpu_we && m != 16'h5000 && m != 16'h5001 && m != 16'h5002)
      |=> ($stable(inner_kind) && $stable(chr_ram_en)));

   p_chr_low_r4: assert property (@(posedge clk) disable iff (rst)
      chr_addr_lo == inner_chr_lo);

   p_inner_low_r6: assert property (@(posedge clk) disable iff (rst)
      !fixed_win |-> prg_addr_lo == inner_prg_lo);

   p_window_low_r7: assert property (@(posedge clk) disable iff (rst)
      fixed_win |-> prg_addr_lo == cpu_addr[12:0]);

   p_mirror_inner_r9: assert property (@(posedge clk) disable iff (rst)
      !fixed_win |-> mirror_h == inner_mirror_h);

   p_swap_hi_r10: assert property (@(posedge clk) disable iff (rst)
      (inner_kind == 2'd3 && cpu_addr[11]) |-> core_addr == {cpu_addr[2], cpu_addr[3]});

endmodule

bind xb_outer_combiner xb_outer_combiner_chk u_chk (
   .clk            (clk),
   .rst            (rst),
   .cpu_addr       (cpu_addr),
   .cpu_wdata_lo   (cpu_wdata[1:0]),
   .cpu_we         (cpu_we),
   .inner_prg_lo   (inner_prg[12:0]),
   .inner_chr_lo   (inner_chr[12:0]),
   .inner_mirror_h (inner_mirror_h),
   .prg_addr_lo    (prg_addr[12:0]),
   .chr_addr_lo    (chr_addr[12:0]),
   .chr_ram_en     (chr_ram_en),
   .mirror_h       (mirror_h),
   .inner_kind     (inner_kind),
   .core_addr      (core_addr),
   .fixed_win      (fixed_win)
);

// File: tb/xb_outer_combiner_test.sv
module xb_outer_combiner_test;

   localparam int PAW = 20;
   localparam int CAW = 19;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic [15:0]    cpu_addr = 16'h0000;
   logic [7:0]     cpu_wdata = 8'h00;
   logic           cpu_we = 1'b0;
   logic [PAW-1:0] inner_prg = '0;
   logic [CAW-1:0] inner_chr = '0;
   logic           inner_mirror_h = 1'b0;
   logic [PAW-1:0] prg_addr;
   logic           prg_in_chr;
   logic [CAW-1:0] chr_addr;
   logic           chr_ram_en;
   logic           mirror_h;
   logic [1:0]     inner_kind;
   logic [1:0]     core_addr;

   xb_outer_combiner uut (
      .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_we(cpu_we),
      .inner_prg(inner_prg), .inner_chr(inner_chr), .inner_mirror_h(inner_mirror_h),
      .prg_addr(prg_addr), .prg_in_chr(prg_in_chr), .chr_addr(chr_addr),
      .chr_ram_en(chr_ram_en), .mirror_h(mirror_h), .inner_kind(inner_kind),
      .core_addr(core_addr)
   );

   always #5 clk = ~clk;

   int    n_tests = 0;
   int    n_fail  = 0;
   bit    running = 1'b0;
   string phase   = "R1";

   // behavioural model state
   int m_cb = 0, m_kind = 0, m_pb = 0, m_mode = 0, m_mir = 0;

   always @(posedge clk) begin
      if (rst) begin
         m_cb = 0; m_kind = 0; m_pb = 0; m_mode = 0; m_mir = 0;
      end else if (cpu_we) begin
         if ((cpu_addr & 16'hF003) == 16'h5000) begin
            m_cb = int'(cpu_wdata) / 4; m_kind = int'(cpu_wdata) % 4;
         end
         if ((cpu_addr & 16'hF003) == 16'h5001) m_pb = int'(cpu_wdata) / 4;
         if ((cpu_addr & 16'hF003) == 16'h5002) m_mode = int'(cpu_wdata);
         if (cpu_addr == 16'h4025) m_mir = (int'(cpu_wdata) / 8) % 2;
      end
   end

   task automatic chk(string what, int act, int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL [%s] %s actual=%0h expected=%0h", phase, what, act, exp);
      end
   endtask

   task automatic compare_all();
      int psz, fx, ram, n, span, src, outer, full, csz, cn, cspan, chr, a, exp_core;
      psz = (m_mode / 4) % 4;
      fx  = (m_mode / 16) % 2;
      ram = m_mode % 2;
      if (psz >= 2)  n = 13;
      else if (fx != 0) n = (psz == 0) ? 15 : 14;
      else           n = (psz == 0) ? 18 : 17;
      span  = 1 << n;
      src   = (fx != 0) ? int'(cpu_addr) % 32768 : int'(inner_prg);
      outer = m_pb * ((ram != 0) ? 32768 : 16384);
      full  = outer - (outer % span) + (src % span);
      chk("prg_addr", int'(prg_addr), full % (1 << 20));
      chk("prg_in_chr", int'(prg_in_chr), full / (1 << 20));
      csz = (m_mode / 16) % 8;
      if (csz >= 4)      cn = 13;
      else if (csz >= 2) cn = 17;
      else if (csz == 1) cn = 15;
      else               cn = 18;
      cspan = 1 << cn;
      chr   = m_cb * 8192;
      chk("chr_addr", int'(chr_addr), chr - (chr % cspan) + (int'(inner_chr) % cspan));
      chk("chr_ram_en", int'(chr_ram_en), ram);
      chk("mirror_h", int'(mirror_h), (fx != 0) ? m_mir : int'(inner_mirror_h));
      chk("inner_kind", int'(inner_kind), m_kind);
      a = int'(cpu_addr);
      if (m_kind == 3) begin
         if ((a / 2048) % 2 != 0) exp_core = ((a / 4) % 2) * 2 + (a / 8) % 2;
         else                     exp_core = ((a / 8) % 2) * 2 + (a / 4) % 2;
      end else exp_core = a % 4;
      chk("core_addr", int'(core_addr), exp_core);
   endtask

   always @(negedge clk) if (running && !rst) compare_all();

   task automatic drive(logic [15:0] a, logic [7:0] d, logic w);
      @(posedge clk); #2;
      cpu_addr = a; cpu_wdata = d; cpu_we = w;
   endtask

   task automatic wr(logic [15:0] a, logic [7:0] d);
      drive(a, d, 1'b1);
      drive(16'h8000, 8'h00, 1'b0);
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      #1_000_000;
      n_tests++; n_fail++;
      $display("FAIL [watchdog] run did not finish actual=hung expected=done");
      finish_run();
   end

   initial begin
      inner_prg = 20'hABCDE; inner_chr = 19'h5A5A5; inner_mirror_h = 1'b1;
      repeat (3) @(posedge clk);
      #2 rst = 1'b0; running = 1'b1;
      // R1: reset state
      phase = "R1";
      drive(16'h8000, 8'h00, 1'b0);
      @(negedge clk);
      chk("R1 kind after reset", int'(inner_kind), 0);
      chk("R1 chr_ram_en after reset", int'(chr_ram_en), 0);
      chk("R1 mirror follows inner", int'(mirror_h), 1);

      // R11: write lands on the next edge, not before
      phase = "R11";
      drive(16'h5000, 8'hAB, 1'b1);
      @(negedge clk);
      chk("R11 kind before edge", int'(inner_kind), 0);
      drive(16'h8000, 8'h00, 1'b0);
      @(negedge clk);
      chk("R11 kind after edge", int'(inner_kind), 3);

      // R3 and R2: aliased slot and stray writes
      phase = "R3";
      wr(16'h5A34, 8'hD6);
      inner_chr = 19'h7FFFF; drive(16'h8000, 8'h00, 1'b0);
      phase = "R2";
      wr(16'h5003, 8'hFF);
      wr(16'h6000, 8'hFF);
      wr(16'h7001, 8'hFF);
      wr(16'h4002, 8'hFF);
      wr(16'h5FF7, 8'hFF);

      // R5: PRG base, low data bits ignored
      phase = "R5";
      wr(16'h5001, 8'hB7);
      wr(16'h5C05, 8'h8B);

      // R4: every CHR span code
      phase = "R4";
      for (int cs = 0; cs < 8; cs++) begin
         wr(16'h5002, 8'((cs * 16) % 256));
         inner_chr = 19'(32'h13579 + cs * 32'h0F0F1);
         drive(16'h8000, 8'h00, 1'b0);
      end

      // R6: every PRG span code in inner-core mode
      phase = "R6";
      for (int ps = 0; ps < 4; ps++) begin
         wr(16'h5002, 8'(ps * 4));
         inner_prg = 20'(32'hFFFFF - ps * 32'h12345);
         drive(16'h8000, 8'h00, 1'b0);
      end

      // R7: fixed window, offsets from the CPU address
      phase = "R7";
      wr(16'h5001, 8'hFC);
      for (int ps = 0; ps < 4; ps++) begin
         wr(16'h5002, 8'(16 + ps * 4));
         drive(16'h8123, 8'h00, 1'b0);
         drive(16'hC456, 8'h00, 1'b0);
         drive(16'hFFFF, 8'h00, 1'b0);
         drive(16'hA000, 8'h00, 1'b0);
      end

      // R8: CHR-RAM mode doubles the PRG space
      phase = "R8";
      for (int ps = 0; ps < 2; ps++) begin
         wr(16'h5002, 8'(1 + ps * 4));
         inner_prg = 20'h3FFFF; drive(16'h8000, 8'h00, 1'b0);
         wr(16'h5001, 8'h84);
         wr(16'h5001, 8'h7C);
      end
      wr(16'h5002, 8'h11);
      drive(16'hBEEF, 8'h00, 1'b0);

      // R9: mirroring register, full address decode
      phase = "R9";
      wr(16'h5002, 8'h10);
      inner_mirror_h = 1'b0;
      wr(16'h4025, 8'h08);
      @(negedge clk);
      chk("R9 fixed window uses register", int'(mirror_h), 1);
      wr(16'h4425, 8'h00);
      wr(16'h4025, 8'hF7);
      inner_mirror_h = 1'b1; drive(16'h8000, 8'h00, 1'b0);
      wr(16'h4025, 8'h08);
      wr(16'h5002, 8'h00);
      inner_mirror_h = 1'b0; drive(16'h8000, 8'h00, 1'b0);

      // R10: register line remap per personality
      phase = "R10";
      for (int k = 0; k < 4; k++) begin
         wr(16'h5000, 8'(k));
         for (int j = 0; j < 8; j++)
            drive(16'(32'h8000 + (j % 2) * 32'h0800 + ((j / 2) % 4) * 4 + j % 4), 8'h00, 1'b0);
      end

      // mixed random traffic across all registers
      phase = "R2";
      for (int i = 0; i < 2500; i++) begin
         logic [15:0] a;
         int sel;
         sel = int'($urandom % 8);
         case (sel)
            0, 1, 2: a = 16'h5000 | (16'($urandom) & 16'h0FFC) | 16'($urandom % 4);
            3:       a = 16'h4025;
            4:       a = 16'h4024 | 16'($urandom % 2) * 16'h0400;
            default: a = 16'($urandom);
         endcase
         inner_prg      = 20'($urandom);
         inner_chr      = 19'($urandom);
         inner_mirror_h = 1'($urandom);
         drive(a, 8'($urandom), ($urandom % 3) == 0);
      end

      drive(16'h8000, 8'h00, 1'b0);
      @(negedge clk);
      running = 1'b0;
      finish_run();
   end

endmodule